// File: doc/BRIEF.md
# Paged memory write controller

This block is the front end of a byte-wide nonvolatile memory model. Its host side looks like a static RAM: an address bus, active-low chip-enable, output-enable and write-enable, and a data bus split into separate in and out ports with an output-enable flag. A write strobe opens a page load. Further strobes to the same page collect bytes into a page register and set a per-byte mask. Each byte restarts an inter-byte timeout. When that timeout runs out, the load window closes and a fixed internal programming timer starts. When the timer ends, only the masked bytes are committed to a behavioural array.

From the first strobe of a load until the commit, the block reports busy. A read during this time returns a status byte instead of array data. Bit 7 is the inverse of the last byte latched, bit 6 flips on every successive read, and bits 5..0 repeat the last byte latched. The host can poll either bit to find the end of the write. A strobe to a different page while the window is open is dropped and flagged.

All durations are clock-cycle parameters. A timing figure of milliseconds scales to a cycle count set by the integrator.

Top module: `pnf_front`

## Requirements
- R1: The byte offset within a page is the low PAGE_W address bits. The page number is the remaining upper bits. A page holds 2**PAGE_W bytes.
- R2: A write strobe is a cycle with ce_n=0, oe_n=1 and we_n=0 that follows a cycle without that condition. A strobe in idle latches address and data, opens a load, and raises busy after that clock edge.
- R3: While loading, a strobe is accepted if it arrives at most LOAD_TO clock edges after the previously accepted strobe. Otherwise the window closes and programming starts. A strobe during programming is ignored.
- R4: Bytes may be loaded in any order. An offset loaded twice in one load commits its most recent value.
- R5: The commit writes only the offsets loaded in that load. All other bytes of the page keep their previous contents.
- R6: A strobe to a page other than the open one, while loading, is ignored. page_err is high for exactly the following cycle.
- R7: busy stays high for exactly LOAD_TO+PROG_CYC clock cycles after the edge of the last accepted strobe. The commit happens at the edge where busy falls.
- R8: While busy, an enabled read returns bit 7 as the complement of bit 7 of the last byte latched.
- R9: While busy, bit 6 of successive reads alternates. It reads 0 on the first read after a load opens. Bits 5..0 show the last byte latched.
- R10: dout_en is high exactly when ce_n=0, oe_n=0 and we_n=1. When dout_en is low, dout is 0.
- R11: After reset, busy and page_err are low and every array byte reads 0.
- R12: Once busy is low, a read returns the true array byte at the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address: page number above the offset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status |
| dout_en | output | 1 | High while dout is driven; low means high impedance |
| busy | output | 1 | Load or programming in progress |
| page_err | output | 1 | One-cycle flag for a dropped strobe to another page |

## Verification
The bench builds the block with ADDR_W=6 and PAGE_W=3, giving eight pages of eight bytes. It uses LOAD_TO=12 and PROG_CYC=30. With this configuration the bench sweeps every non-empty byte mask of a page, 255 loads over all eight pages. Each load checks the whole page against an arithmetic model, so untouched neighbours and the latest-value rule are covered for every mask. The short timers let the bench place a strobe exactly at the last accepted edge of the window and one edge past it. They also make it cheap to measure the busy length and the status-byte sequence on every load.

// File: rtl/pnf_pkg.sv
package pnf_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LOAD = 2'd1,
    PS_PROG = 2'd2
  } pnf_state_t;

  // Status byte presented while a write is in flight.
  function automatic logic [7:0] status_byte(input logic [7:0] last, input logic tog);
    return {~last[7], tog, last[5:0]};
  endfunction

endpackage

// File: rtl/pnf_strobe.sv
module pnf_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_evt,
  output logic rd_evt,
  output logic rd_on
);
  logic wr_cond, wr_q, rd_q;

  assign wr_cond = ~ce_n & oe_n & ~we_n;
  assign rd_on   = ~ce_n & ~oe_n & we_n;
  assign wr_evt  = wr_cond & ~wr_q;
  assign rd_evt  = rd_on & ~rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_cond;
      rd_q <= rd_on;
    end
  end
endmodule

// File: rtl/pnf_seq.sv
module pnf_seq
  import pnf_pkg::*;
#(
  parameter int LOAD_TO  = 12,
  parameter int PROG_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_evt,
  input  logic same_page,
  output logic accept,
  output logic start,
  output logic commit,
  output logic in_prog,
  output logic busy,
  output logic err_q
);
  localparam int LCW = $clog2(LOAD_TO + 1);
  localparam int PCW = $clog2(PROG_CYC + 1);

  pnf_state_t st;
  logic [LCW-1:0] lcnt;
  logic [PCW-1:0] pcnt;
  logic mismatch, load_end;

  assign start    = wr_evt && (st == PS_IDLE);
  assign accept   = start || (wr_evt && (st == PS_LOAD) && same_page);
  assign mismatch = wr_evt && (st == PS_LOAD) && !same_page;
  assign load_end = (st == PS_LOAD) && !accept && (lcnt == LCW'(LOAD_TO - 1));
  assign commit   = (st == PS_PROG) && (pcnt == PCW'(PROG_CYC - 1));
  assign in_prog  = (st == PS_PROG);
  assign busy     = (st != PS_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PS_IDLE;
      lcnt  <= '0;
      pcnt  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= mismatch;
      unique case (st)
        PS_IDLE: if (start) begin
          st   <= PS_LOAD;
          lcnt <= '0;
        end
        PS_LOAD: begin
          if (accept)        lcnt <= '0;
          else if (load_end) begin
            st   <= PS_PROG;
            pcnt <= '0;
          end else           lcnt <= lcnt + 1'b1;
        end
        PS_PROG: begin
          if (commit) st <= PS_IDLE;
          else        pcnt <= pcnt + 1'b1;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pnf_page_buf.sv
module pnf_page_buf #(
  parameter int PAGE_W = 3,
  parameter int TAG_W  = 3,
  localparam int PAGE_N = 1 << PAGE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   start,
  input  logic                   commit,
  input  logic [PAGE_W-1:0]      offs,
  input  logic [TAG_W-1:0]       tag,
  input  logic [7:0]             din,
  output logic [PAGE_N-1:0][7:0] pbuf,
  output logic [PAGE_N-1:0]      mask,
  output logic [TAG_W-1:0]       open_tag,
  output logic [7:0]             last_b
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pbuf     <= '0;
      mask     <= '0;
      open_tag <= '0;
      last_b   <= '0;
    end else begin
      if (start)  open_tag <= tag;
      if (accept) last_b   <= din;
      for (int i = 0; i < PAGE_N; i++) begin
        if (commit) mask[i] <= 1'b0;
        else if (accept && (offs == PAGE_W'(i))) begin
          mask[i] <= 1'b1;
          pbuf[i] <= din;
        end
      end
    end
  end
endmodule

// File: rtl/pnf_array.sv
module pnf_array #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7,
  localparam int PAGE_N = 1 << PAGE_W,
  localparam int TAG_W  = ADDR_W - PAGE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [TAG_W-1:0]       tag,
  input  logic [PAGE_N-1:0][7:0] pbuf,
  input  logic [PAGE_N-1:0]      mask,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= 8'h00;
    end else if (commit) begin
      for (int i = 0; i < PAGE_N; i++)
        if (mask[i]) mem[{tag, PAGE_W'(i)}] <= pbuf[i];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pnf_front.sv
module pnf_front
  import pnf_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 7,
  parameter int LOAD_TO  = 12,
  parameter int PROG_CYC = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int TAG_W  = ADDR_W - PAGE_W;

  // Named internal events, also used by the bound checker.
  logic wr_evt, rd_evt, rd_on;
  logic accept, start, commit, in_prog;
  logic same_page, tog_q;
  logic [TAG_W-1:0]       open_tag;
  logic [PAGE_N-1:0][7:0] pbuf;
  logic [PAGE_N-1:0]      mask;
  logic [7:0]             last_b, arr_rd;

  wire [TAG_W-1:0]  a_tag  = addr[ADDR_W-1:PAGE_W];
  wire [PAGE_W-1:0] a_offs = addr[PAGE_W-1:0];

  assign same_page = (a_tag == open_tag);

  pnf_strobe u_strobe (
    .clk, .rst_n, .ce_n, .oe_n, .we_n,
    .wr_evt, .rd_evt, .rd_on
  );

  pnf_seq #(.LOAD_TO(LOAD_TO), .PROG_CYC(PROG_CYC)) u_seq (
    .clk, .rst_n, .wr_evt, .same_page,
    .accept, .start, .commit, .in_prog, .busy, .err_q(page_err)
  );

  pnf_page_buf #(.PAGE_W(PAGE_W), .TAG_W(TAG_W)) u_buf (
    .clk, .rst_n, .accept, .start, .commit,
    .offs(a_offs), .tag(a_tag), .din,
    .pbuf, .mask, .open_tag, .last_b
  );

  pnf_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk, .rst_n, .commit, .tag(open_tag), .pbuf, .mask,
    .rd_addr(addr), .rd_data(arr_rd)
  );

  // Toggle bit: cleared when a load opens, flips on each read while busy.
  always_ff @(posedge clk) begin
    if (!rst_n)              tog_q <= 1'b0;
    else if (start)          tog_q <= 1'b0;
    else if (rd_evt && busy) tog_q <= ~tog_q;
  end

  assign dout_en = rd_on;
  always_comb begin
    if (!rd_on)    dout = 8'h00;
    else if (busy) dout = status_byte(last_b, tog_q);
    else           dout = arr_rd;
  end
endmodule

// File: rtl/pnf_chk.sv
module pnf_chk #(
  parameter int PROG_CYC = 30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       commit,
  input logic       in_prog,
  input logic       page_err,
  input logic       dout_en,
  input logic [7:0] dout,
  input logic       rd_evt,
  input logic       tog_q,
  input logic [7:0] last_b
);
  int pcyc;
  always_ff @(posedge clk) begin
    if (!rst_n || !in_prog) pcyc <= 0;
    else                    pcyc <= pcyc + 1;
  end

  AST_PROG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (pcyc == PROG_CYC - 1)); // R7
  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy); // R7
  AST_ERR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> busy); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> !page_err || busy); // R6
  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_en) |-> (dout[7] != last_b[7])); // R8
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_evt) |=> (tog_q != $past(tog_q))); // R9
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00)); // R10
endmodule

bind pnf_front pnf_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .commit(commit), .in_prog(in_prog),
  .page_err(page_err), .dout_en(dout_en), .dout(dout), .rd_evt(rd_evt),
  .tog_q(tog_q), .last_b(last_b)
);

// File: tb/sim_pnf_front.sv
module sim_pnf_front;
  localparam int AW = 6, PW = 3, LT = 12, PC = 30;
  localparam int PN = 1 << PW, NPG = 1 << (AW - PW), DEP = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, busy, page_err;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0] mdl [DEP];
  logic err_seen;

  always #10 clk = ~clk;

  pnf_front #(.ADDR_W(AW), .PAGE_W(PW), .LOAD_TO(LT), .PROG_CYC(PC)) u0 (
    .clk, .rst_n, .addr, .ce_n, .oe_n, .we_n, .din,
    .dout, .dout_en, .busy, .page_err
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // One strobe edge, then one release edge.
  task automatic wr(input int a, input logic [7:0] d);
    addr = AW'(a); din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk);
    err_seen = page_err;
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 v = dout;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_free(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  function automatic logic [7:0] pat(input int m, input int i);
    return 8'((m * 37 + i * 91 + 5) ^ (i << 5));
  endfunction

  task automatic check_page(input int p, input string req);
    logic [7:0] v;
    for (int i = 0; i < PN; i++) begin
      rd(p * PN + i, v);
      chk(req, v, mdl[p * PN + i]);
    end
  endtask

  initial begin
    logic [7:0] v;
    int n;
    for (int a = 0; a < DEP; a++) mdl[a] = 8'h00;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11 busy", busy, 0);
    chk("R11 err", page_err, 0);
    for (int a = 0; a < DEP; a += 9) begin
      rd(a, v);
      chk("R11 array", v, 0);
    end

    // R10: enable rule, skipping the write combination
    for (int c = 0; c < 8; c++) begin
      if (c == 3'b010) continue; // ce=0 oe=1 we=0 would be a strobe
      ce_n = c[2]; oe_n = c[1]; we_n = c[0];
      #1;
      chk("R10 dout_en", dout_en, (!c[2] && !c[1] && c[0]));
      if (!dout_en) chk("R10 dout idle", dout, 0);
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
    end

    // R8, R9, R2, R12: status polling during one load
    wr(6 * PN + 3, 8'hA5);
    chk("R2 busy rises", busy, 1);
    mdl[6 * PN + 3] = 8'hA5;
    rd(0, v);  chk("R9 first read", v, 8'h25);
    rd(5, v);  chk("R9 second read", v, 8'h65);
    rd(63, v); chk("R8 third read", v, 8'h25);
    wait_free(n);
    rd(6 * PN + 3, v);
    chk("R12 true data", v, 8'hA5);

    // R3: strobe at the last accepted edge and one edge past the window
    wr(5 * PN + 1, 8'h11);
    idle(LT - 2);
    wr(5 * PN + 2, 8'h22);
    idle(LT - 1);
    wr(5 * PN + 3, 8'h33);
    mdl[5 * PN + 1] = 8'h11;
    mdl[5 * PN + 2] = 8'h22;
    wait_free(n);
    check_page(5, "R3 window");

    // R6: strobe to another page is dropped and flagged
    wr(2 * PN + 0, 8'h44);
    wr(3 * PN + 0, 8'h55);
    chk("R6 err pulse", err_seen, 1);
    @(negedge clk);
    chk("R6 err clears", page_err, 0);
    mdl[2 * PN] = 8'h44;
    wait_free(n);
    check_page(2, "R6 open page");
    check_page(3, "R6 other page");

    // R1, R4, R5, R7: every non-empty mask, page picked from the mask
    for (int m = 1; m < 256; m++) begin
      int p = m % NPG;
      if (m[0]) wr(p * PN, ~pat(m, 0)); // overwritten below
      for (int i = PN - 1; i >= 0; i--)
        if (m[i]) begin
          wr(p * PN + i, pat(m, i));
          mdl[p * PN + i] = pat(m, i);
        end
      wait_free(n);
      chk("R7 busy length", n, LT + PC - 1);
      check_page(p, "R5 R4 R1 page contents");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule